// File: doc/BRIEF.md
# Hot-Plug Slot Command Engine

This block is the command side of a hot-plug slot controller. Host software writes a 16-bit command word. The word holds a target slot number and a command code. The engine raises a busy flag and counts down a programmable execution delay, which stands in for real power sequencing. When the delay ends, it applies the command and sets a completion latch. That latch feeds bit 0 of the interrupt locator.

Commands fall into four groups:
- Slot-field updates, which change the slot state, the power indicator and the attention indicator of one slot.
- Two tables of bus speed/mode selections.
- A power-up of every slot.
- An enable of every slot.

Commands that cannot run leave all state untouched and report one of three error codes in the status word. The causes are an undefined code, an out-of-range slot, an unsupported speed/mode, or an open retention latch.

The command input is a plain write strobe with no back-pressure. A write that arrives while busy is dropped. Software must poll status bit 0 before it writes again.

Top module: `hp_cmd_engine`

## Requirements
- R1: A command word holds the target slot in bits 15:8 and the code in bits 7:0. A write accepted while idle sets status bit 0 (busy) from the next cycle. Busy stays high for exactly `delay_cycles`+1 cycles.
- R2: A write that arrives while busy has no effect. The command in progress is not restarted, and the dropped command is never executed.
- R3: Codes 0x00 to 0x3F update the target slot when busy falls, with three fields:
  - Bits 1:0 set the slot state: 1 = powered only, 2 = enabled, 3 = disabled.
  - Bits 3:2 set the power indicator: 1 = on, 2 = blink, 3 = off.
  - Bits 5:4 set the attention indicator, with the same encoding as the power indicator.
  - A zero field leaves that field unchanged.
  - Slot i occupies bits 2i+1:2i of `slot_state`, `power_ind` and `attn_ind`.
- R4: Code 0x3A enables the slot, sets the power indicator to blink and turns attention off. Code 0x1F disables the slot, turns the power indicator off and turns attention on.
- R5: Codes 0x40 to 0x44 set `bus_mode` to 0 to 4 (PCI 33, PCI 66, PCI-X 66, PCI-X 100, PCI-X 133). Codes 0x45 to 0x47 are reserved and give the invalid-command error.
- R6: Codes 0x50 to 0x5D set `bus_mode` to code minus 0x50 (0 to 13). When `ext_modes_en` is 0, any such code whose mode is above 4 gives the invalid speed/mode error (status bit 3) and leaves `bus_mode` unchanged.
- R7: Code 0x48 sets every slot state to powered-only (1). Code 0x49 sets every slot state to enabled (2).
- R8: A slot operation whose target is at or beyond NUM_SLOTS, or any undefined code, gives the invalid-command error (status bit 2) and changes no state.
- R9: Some commands need the retention latch closed:
  - A slot operation whose state field is 1 or 2 fails if the target slot's `latch_open` is set.
  - 0x48 and 0x49 fail if any slot's `latch_open` is set.
  - The failure gives the switch-open error (status bit 1) and changes no state.
- R10: Status bits 3:1 are replaced only when busy falls. At most one of them is set, and a successful command clears all three.
- R11: `done_event` is set when busy falls and holds until `done_clear` is high at a clock edge. A completion in the same cycle as a clear wins.
- R12: After reset, the block is in this state:
  - status is 0;
  - every slot is disabled (3), with both indicators off (3);
  - `bus_mode` is 0;
  - `done_event` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_word | input | 16 | Slot number [15:8], command code [7:0] |
| delay_cycles | input | DELAY_W | Execution delay; busy lasts this value plus one cycles |
| ext_modes_en | input | 1 | 1 allows speed/modes above PCI-X 133 |
| latch_open | input | NUM_SLOTS | Retention latch open, one bit per slot |
| done_clear | input | 1 | Write-one-to-clear for the completion latch |
| status | output | 4 | {bad speed/mode, invalid command, switch open, busy} |
| slot_state | output | 2*NUM_SLOTS | Per-slot state |
| power_ind | output | 2*NUM_SLOTS | Per-slot power indicator |
| attn_ind | output | 2*NUM_SLOTS | Per-slot attention indicator |
| bus_mode | output | 4 | Current bus speed/mode |
| done_event | output | 1 | Command-complete latch (interrupt locator bit 0) |

## Verification
The hardest situations to reach are collisions with the busy window:
- a second write that lands in the middle of a long delay;
- a clear of the completion latch that falls on the very cycle the command finishes.

The bench reaches the first case by using a ten-cycle delay and driving a second, state-changing write two cycles into the window. It then shows that busy lasts exactly eleven cycles and that the dropped target slot stays untouched. For the second case, it holds the clear high across a zero-delay command, so the completion edge and the clear coincide.

// File: rtl/hp_cmd_pkg.sv
package hp_cmd_pkg;

  typedef enum logic [2:0] {
    K_SLOT, K_SETA, K_SETB, K_PWRALL, K_ENALL, K_BAD
  } cmd_kind_e;

  // packed so that {err, busy} gives status bits 3..0
  typedef struct packed {
    logic speed;
    logic inval;
    logic sw_open;
  } err_t;

  function automatic cmd_kind_e classify(input logic [7:0] c);
    if (c <= 8'h3F)                     return K_SLOT;
    else if (c >= 8'h40 && c <= 8'h44)  return K_SETA;
    else if (c == 8'h48)                return K_PWRALL;
    else if (c == 8'h49)                return K_ENALL;
    else if (c >= 8'h50 && c <= 8'h5D)  return K_SETB;
    else                                return K_BAD;
  endfunction

endpackage

// File: rtl/hp_cmd_seq.sv
module hp_cmd_seq #(
  parameter int DELAY_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_wr,
  input  logic [15:0]        cmd_word,
  input  logic [DELAY_W-1:0] delay_cycles,
  output logic               busy,
  output logic               done,
  output logic [15:0]        cmd_q
);
  logic [DELAY_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt   <= '0;
      cmd_q <= '0;
    end else if (!busy) begin
      if (cmd_wr) begin
        busy  <= 1'b1;
        cnt   <= delay_cycles;
        cmd_q <= cmd_word;
      end
    end else if (cnt == '0) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done = busy && (cnt == '0);

  assert_busy_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_wr));

  assert_ignore_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cmd_q));

endmodule

// File: rtl/hp_cmd_decode.sv
module hp_cmd_decode
  import hp_cmd_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int SW        = 2
) (
  input  logic [15:0]          cmd_q,
  input  logic [NUM_SLOTS-1:0] latch_open,
  input  logic                 ext_modes_en,
  output err_t                 err,
  output logic [NUM_SLOTS-1:0] upd,
  output logic [1:0]           f_st,
  output logic [1:0]           f_pw,
  output logic [1:0]           f_at,
  output logic                 mode_we,
  output logic [3:0]           mode_val
);
  logic [7:0]   code;
  logic [7:0]   tgt;
  logic [SW-1:0] tsel;
  cmd_kind_e    kind;

  assign code = cmd_q[7:0];
  assign tgt  = cmd_q[15:8];
  assign tsel = tgt[SW-1:0];
  assign kind = classify(code);

  always_comb begin
    err      = '0;
    upd      = '0;
    f_st     = 2'd0;
    f_pw     = 2'd0;
    f_at     = 2'd0;
    mode_we  = 1'b0;
    mode_val = 4'd0;
    unique case (kind)
      K_SLOT: begin
        if (int'(tgt) >= NUM_SLOTS) begin
          err.inval = 1'b1;
        end else if ((code[1:0] == 2'd1 || code[1:0] == 2'd2) && latch_open[tsel]) begin
          err.sw_open = 1'b1;
        end else begin
          upd[tsel] = 1'b1;
          f_st = code[1:0];
          f_pw = code[3:2];
          f_at = code[5:4];
        end
      end
      K_SETA: begin
        mode_we  = 1'b1;
        mode_val = {1'b0, code[2:0]};
      end
      K_SETB: begin
        if (!ext_modes_en && code[3:0] > 4'd4) begin
          err.speed = 1'b1;
        end else begin
          mode_we  = 1'b1;
          mode_val = code[3:0];
        end
      end
      K_PWRALL, K_ENALL: begin
        if (|latch_open) begin
          err.sw_open = 1'b1;
        end else begin
          upd  = '1;
          f_st = (kind == K_PWRALL) ? 2'd1 : 2'd2;
        end
      end
      default: err.inval = 1'b1;
    endcase
  end

endmodule

// File: rtl/hp_slot_bank.sv
module hp_slot_bank #(
  parameter int NUM_SLOTS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [NUM_SLOTS-1:0]   upd,
  input  logic [1:0]             f_st,
  input  logic [1:0]             f_pw,
  input  logic [1:0]             f_at,
  output logic [2*NUM_SLOTS-1:0] slot_state,
  output logic [2*NUM_SLOTS-1:0] power_ind,
  output logic [2*NUM_SLOTS-1:0] attn_ind
);
  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic [1:0] st_r, pw_r, at_r;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_r <= 2'd3;
        pw_r <= 2'd3;
        at_r <= 2'd3;
      end else if (we && upd[i]) begin
        if (f_st != 2'd0) st_r <= f_st;
        if (f_pw != 2'd0) pw_r <= f_pw;
        if (f_at != 2'd0) at_r <= f_at;
      end
    end

    assign slot_state[2*i +: 2] = st_r;
    assign power_ind[2*i +: 2]  = pw_r;
    assign attn_ind[2*i +: 2]   = at_r;

    assert_field_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_r != 2'd0) && (pw_r != 2'd0) && (at_r != 2'd0));
  end

endmodule

// File: rtl/hp_cmd_engine.sv
module hp_cmd_engine
  import hp_cmd_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int DELAY_W   = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_wr,
  input  logic [15:0]            cmd_word,
  input  logic [DELAY_W-1:0]     delay_cycles,
  input  logic                   ext_modes_en,
  input  logic [NUM_SLOTS-1:0]   latch_open,
  input  logic                   done_clear,
  output logic [3:0]             status,
  output logic [2*NUM_SLOTS-1:0] slot_state,
  output logic [2*NUM_SLOTS-1:0] power_ind,
  output logic [2*NUM_SLOTS-1:0] attn_ind,
  output logic [3:0]             bus_mode,
  output logic                   done_event
);
  localparam int SW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  logic                 busy, done;
  logic [15:0]          cmd_q;
  err_t                 err_d, err_q;
  logic [NUM_SLOTS-1:0] upd;
  logic [1:0]           f_st, f_pw, f_at;
  logic                 mode_we;
  logic [3:0]           mode_val, mode_q;
  logic                 cc_q;

  hp_cmd_seq #(.DELAY_W(DELAY_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
    .delay_cycles(delay_cycles), .busy(busy), .done(done), .cmd_q(cmd_q)
  );

  hp_cmd_decode #(.NUM_SLOTS(NUM_SLOTS), .SW(SW)) u_dec (
    .cmd_q(cmd_q), .latch_open(latch_open), .ext_modes_en(ext_modes_en),
    .err(err_d), .upd(upd), .f_st(f_st), .f_pw(f_pw), .f_at(f_at),
    .mode_we(mode_we), .mode_val(mode_val)
  );

  hp_slot_bank #(.NUM_SLOTS(NUM_SLOTS)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(done), .upd(upd),
    .f_st(f_st), .f_pw(f_pw), .f_at(f_at),
    .slot_state(slot_state), .power_ind(power_ind), .attn_ind(attn_ind)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q  <= '0;
      mode_q <= 4'd0;
      cc_q   <= 1'b0;
    end else begin
      if (done) begin
        err_q <= err_d;
        if (mode_we) mode_q <= mode_val;
      end
      if (done)            cc_q <= 1'b1;
      else if (done_clear) cc_q <= 1'b0;
    end
  end

  assign status     = {err_q, busy};
  assign bus_mode   = mode_q;
  assign done_event = cc_q;

  assert_cc_on_finish_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cc_q) |-> $fell(busy));

  assert_err_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(busy) |-> $stable(err_q));

  assert_err_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(err_q));

  assert_mode_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(busy) |-> $stable(mode_q));

endmodule

// File: tb/test_hp_cmd_engine.sv
module test_hp_cmd_engine;
  localparam int N  = 4;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_wr = 1'b0;
  logic [15:0]   cmd_word = '0;
  logic [DW-1:0] delay_cycles = '0;
  logic          ext_modes_en = 1'b0;
  logic [N-1:0]  latch_open = '0;
  logic          done_clear = 1'b0;
  logic [3:0]    status;
  logic [2*N-1:0] slot_state, power_ind, attn_ind;
  logic [3:0]    bus_mode;
  logic          done_event;

  int checks = 0;
  int failures = 0;
  int nbusy;

  always #10 clk = ~clk;

  hp_cmd_engine #(.NUM_SLOTS(N), .DELAY_W(DW)) i_hp_cmd_engine (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
    .delay_cycles(delay_cycles), .ext_modes_en(ext_modes_en),
    .latch_open(latch_open), .done_clear(done_clear), .status(status),
    .slot_state(slot_state), .power_ind(power_ind), .attn_ind(attn_ind),
    .bus_mode(bus_mode), .done_event(done_event)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // issue a command and wait for completion; counts busy cycles
  task automatic issue(input logic [15:0] w, output int n);
    @(negedge clk);
    cmd_wr = 1'b1; cmd_word = w;
    @(negedge clk);
    cmd_wr = 1'b0;
    n = 0;
    while (status[0] && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk("R12", "status", 32'(status), 0);
    chk("R12", "slot_state", 32'(slot_state), 32'hFF);
    chk("R12", "power_ind", 32'(power_ind), 32'hFF);
    chk("R12", "attn_ind", 32'(attn_ind), 32'hFF);
    chk("R12", "bus_mode", 32'(bus_mode), 0);
    chk("R12", "done_event", 32'(done_event), 0);
  endtask

  task automatic t_busy_window();
    int n;
    delay_cycles = 5;
    issue(16'h0000, n);
    chk("R1", "busy cycles", 32'(n), 6);
    chk("R11", "done_event set", 32'(done_event), 1);
    @(negedge clk); done_clear = 1'b1;
    @(negedge clk); done_clear = 1'b0;
    chk("R11", "done_event cleared", 32'(done_event), 0);
  endtask

  task automatic t_slot_fields();
    int n;
    delay_cycles = 2;
    issue({8'd1, 8'h3A}, n);
    chk("R4", "0x3A state", 32'(slot_state), 32'hFB);
    chk("R4", "0x3A power", 32'(power_ind), 32'hFB);
    chk("R4", "0x3A attn", 32'(attn_ind), 32'hFF);
    issue({8'd2, 8'h04}, n);
    chk("R3", "zero state field unchanged", 32'(slot_state), 32'hFB);
    chk("R3", "power field only", 32'(power_ind), 32'hDB);
    issue({8'd1, 8'h1F}, n);
    chk("R4", "0x1F state", 32'(slot_state), 32'hFF);
    chk("R4", "0x1F power", 32'(power_ind), 32'hDF);
    chk("R4", "0x1F attn", 32'(attn_ind), 32'hF7);
  endtask

  task automatic t_ignore_busy();
    int n;
    delay_cycles = 10;
    @(negedge clk);
    cmd_wr = 1'b1; cmd_word = {8'd0, 8'h3A};
    @(negedge clk);
    cmd_wr = 1'b0;
    n = 0;
    for (int k = 0; k < 2; k++) begin
      if (status[0]) n++;
      @(negedge clk);
    end
    cmd_wr = 1'b1; cmd_word = {8'd3, 8'h3A};
    if (status[0]) n++;
    @(negedge clk);
    cmd_wr = 1'b0;
    while (status[0] && n < 5000) begin
      n++;
      @(negedge clk);
    end
    chk("R2", "busy not restarted", 32'(n), 11);
    chk("R2", "dropped slot3 untouched", 32'(slot_state), 32'hFE);
    chk("R2", "power", 32'(power_ind), 32'hDE);
    chk("R2", "still idle after window", 32'(status), 0);
  endtask

  task automatic t_speed();
    int n;
    delay_cycles = 1;
    ext_modes_en = 1'b0;
    issue(16'h0043, n);
    chk("R5", "set A 0x43", 32'(bus_mode), 3);
    chk("R5", "status ok", 32'(status), 0);
    issue(16'h0045, n);
    chk("R5", "reserved invalid", 32'(status), 4);
    chk("R5", "mode kept", 32'(bus_mode), 3);
    issue(16'h0052, n);
    chk("R6", "set B low mode at level 1", 32'(bus_mode), 2);
    issue(16'h0058, n);
    chk("R6", "level 1 bad speed", 32'(status), 8);
    chk("R6", "mode unchanged", 32'(bus_mode), 2);
    ext_modes_en = 1'b1;
    issue(16'h005D, n);
    chk("R6", "set B 0x5D", 32'(bus_mode), 13);
    chk("R10", "errors cleared by success", 32'(status), 0);
    ext_modes_en = 1'b0;
  endtask

  task automatic t_invalid();
    int n;
    issue({8'd4, 8'h01}, n);
    chk("R8", "slot out of range", 32'(status), 4);
    chk("R8", "state unchanged", 32'(slot_state), 32'hFE);
    issue(16'h0060, n);
    chk("R8", "undefined 0x60", 32'(status), 4);
    issue(16'h005E, n);
    chk("R8", "undefined 0x5E", 32'(status), 4);
    chk("R8", "mode unchanged", 32'(bus_mode), 13);
  endtask

  task automatic t_latch();
    int n;
    latch_open = 4'b0100;
    issue({8'd2, 8'h02}, n);
    chk("R9", "enable with latch open", 32'(status), 2);
    chk("R9", "state unchanged", 32'(slot_state), 32'hFE);
    issue({8'd2, 8'h08}, n);
    chk("R9", "indicator allowed", 32'(status), 0);
    chk("R9", "power blink slot2", 32'(power_ind), 32'hEE);
    issue(16'h0048, n);
    chk("R9", "power-all blocked", 32'(status), 2);
    chk("R9", "power-all no change", 32'(slot_state), 32'hFE);
    latch_open = '0;
    issue(16'h0048, n);
    chk("R7", "power all", 32'(slot_state), 32'h55);
    issue(16'h0049, n);
    chk("R7", "enable all", 32'(slot_state), 32'hAA);
    chk("R10", "status ok", 32'(status), 0);
  endtask

  task automatic t_clear_collision();
    int n;
    delay_cycles = 0;
    @(negedge clk); done_clear = 1'b1;
    @(negedge clk);
    chk("R11", "cleared before", 32'(done_event), 0);
    issue(16'h0000, n);
    chk("R1", "zero delay busy one cycle", 32'(n), 1);
    chk("R11", "set wins over clear", 32'(done_event), 1);
    @(negedge clk);
    chk("R11", "clear afterwards", 32'(done_event), 0);
    done_clear = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_busy_window();
    t_slot_fields();
    t_ignore_busy();
    t_speed();
    t_invalid();
    t_latch();
    t_clear_collision();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule